// File: doc/BRIEF.md
# Power-Down Mode Transition Controller

This block holds the operating mode of a small processor core and moves it between three running modes (high-speed, medium-speed, subactive) and four stopped modes (sleep, subsleep, standby, watch). Software sets a handful of control bits through a simple write port, then raises a one-cycle sleep strobe. The controller picks the stopped mode, or the other running mode, that those bits name and that the current mode allows. A later wake strobe returns the core to a running mode. The controller drives an enable for the main oscillator clock and an enable for the processor clock. Oscillator start-up is seen only as a ready input.

The low-speed flag has two jobs. It selects which sleep targets are reachable from each running mode, and it decides whether leaving watch mode resumes at high-speed or at subactive. Any request that is not on the allowed list leaves the mode as it was. On any return to high-speed or medium-speed from a mode in which the main clock was off, the processor clock stays gated until the oscillator reports ready.

Control register fields (write data / readback): bit 0 low-speed flag, bit 1 standby select, bit 2 direct-transfer select, bit 3 medium-speed select. All higher bits read 0.

Top module: `pdm_mode_ctrl_top`

## Requirements
- R1: Under synchronous active-low reset the mode is high-speed (code 0), the control register reads 0, and both clock enables are 1.
- R2: A write (regWrEn high at a clock edge) loads bits 3:0 of regWrData into the control register (bit 0 low-speed, bit 1 standby select, bit 2 direct select, bit 3 medium select). The register appears on ctrlRd after that edge, and bits above 3 always read 0.
- R3: With the low-speed flag 0, a sleep strobe in high-speed or medium-speed mode goes to sleep for {standby,direct}=00, to standby for 10, and to watch for 01.
- R4: With the low-speed flag 1, a sleep strobe in high-speed mode goes to sleep for {standby,direct}=00, to standby for 10, to subactive for 01, and to watch for 11.
- R5: In subactive mode, a sleep strobe goes to watch for {standby,direct}=10 with either flag value. With the flag 0 it goes straight to high-speed for 01; with the flag 1 it goes to subsleep for 00.
- R6: A sleep strobe whose combination is not listed in R3 to R5 leaves the mode unchanged. This includes every sleep strobe in medium-speed mode while the flag is 1.
- R7: A wake strobe in sleep or standby returns to the running mode that was left: high-speed or medium-speed. A wake strobe in subsleep returns to subactive.
- R8: A wake strobe in watch mode goes to subactive when the low-speed flag is 1 and to high-speed when it is 0.
- R9: On entering high-speed or medium-speed from subactive, standby or watch, cpuClkEn is 0. It stays 0 until the clock edge at which oscReady is sampled high, and it rises after that edge.
- R10: mainClkEn is 1 exactly in high-speed, medium-speed and sleep. cpuClkEn is 1 in subactive, and in high-speed or medium-speed when no oscillator wait is pending; it is 0 otherwise.
- R11: While the processor clock runs and no sleep transition is taken, high-speed moves to medium-speed when the medium select bit is 1, and medium-speed moves to high-speed when the bit is 0.
- R12: A sleep strobe has no effect while the processor clock is off. A wake strobe has no effect in a running mode.
- R13: modeCode uses the codes high-speed 0, medium-speed 1, subactive 2, sleep 3, subsleep 4, standby 5, watch 6. Code 7 never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | DATA_W | Control register write data |
| ctrlRd | output | DATA_W | Control register readback |
| sleepStrobe | input | 1 | One-cycle sleep request |
| wakeStrobe | input | 1 | One-cycle wake request |
| oscReady | input | 1 | Main oscillator settled |
| modeCode | output | 3 | Current mode code |
| mainClkEn | output | 1 | Main oscillator clock enable |
| cpuClkEn | output | 1 | Processor clock enable |

## Verification
Every result is due one clock edge after the stimulus that causes it. A sleep or wake strobe sampled at an edge shows its new mode, and the enables that follow from it, right after that edge. A register write shows on ctrlRd after its edge. A change of the medium select bit moves the mode one edge after the write, because the selection is made from the stored register. The processor clock enable rises one edge after oscReady is sampled high. The bench drives inputs on the falling edge. At each rising edge it advances a behavioural model from the same inputs, and on the next falling edge it compares all four outputs, so each expectation is read in the cycle the output settles.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  typedef enum logic [2:0] {
    MODE_HIGH   = 3'd0,
    MODE_MED    = 3'd1,
    MODE_SUB    = 3'd2,
    MODE_SLEEP  = 3'd3,
    MODE_SUBSLP = 3'd4,
    MODE_STBY   = 3'd5,
    MODE_WATCH  = 3'd6,
    MODE_BAD    = 3'd7
  } pdmMode_e;

  localparam int CTRL_BITS = 4;

  typedef struct packed {
    logic mediumSel;
    logic directSel;
    logic standbySel;
    logic lowSpeedOn;
  } pdmCtrl_t;

  typedef struct packed {
    logic     loadMode;
    pdmMode_e nextMode;
    logic     saveOrigin;
    logic     originMed;
    logic     setWait;
    logic     clrWait;
  } pdmStrobe_t;

endpackage

// File: rtl/pdm_ctrl.sv
module pdm_ctrl
  import pdm_pkg::*;
(
  input  pdmMode_e   mode,
  input  pdmCtrl_t   ctrl,
  input  logic       waitOsc,
  input  logic       origMed,
  input  logic       sleepStrobe,
  input  logic       wakeStrobe,
  input  logic       oscReady,
  output pdmStrobe_t strb
);

  logic     isFast;
  logic     cpuRun;
  logic     isStopped;
  logic     mainOff;
  logic     sleepLegal;
  pdmMode_e sleepTgt;
  pdmMode_e wakeTgt;
  logic [1:0] sel;

  assign sel       = {ctrl.standbySel, ctrl.directSel};
  assign isFast    = (mode == MODE_HIGH) || (mode == MODE_MED);
  assign cpuRun    = (isFast && !waitOsc) || (mode == MODE_SUB);
  assign isStopped = (mode == MODE_SLEEP) || (mode == MODE_SUBSLP) ||
                     (mode == MODE_STBY)  || (mode == MODE_WATCH);
  assign mainOff   = (mode == MODE_SUB) || (mode == MODE_STBY) || (mode == MODE_WATCH);

  // legal sleep targets per running mode and flag
  always_comb begin
    sleepTgt   = mode;
    sleepLegal = 1'b0;
    case (mode)
      MODE_HIGH, MODE_MED: begin
        if (!ctrl.lowSpeedOn) begin
          case (sel)
            2'b00:   begin sleepTgt = MODE_SLEEP; sleepLegal = 1'b1; end
            2'b10:   begin sleepTgt = MODE_STBY;  sleepLegal = 1'b1; end
            2'b01:   begin sleepTgt = MODE_WATCH; sleepLegal = 1'b1; end
            default: sleepLegal = 1'b0;
          endcase
        end else if (mode == MODE_HIGH) begin
          sleepLegal = 1'b1;
          case (sel)
            2'b00:   sleepTgt = MODE_SLEEP;
            2'b10:   sleepTgt = MODE_STBY;
            2'b01:   sleepTgt = MODE_SUB;
            default: sleepTgt = MODE_WATCH;
          endcase
        end
      end
      MODE_SUB: begin
        if (sel == 2'b10) begin
          sleepTgt = MODE_WATCH; sleepLegal = 1'b1;
        end else if (!ctrl.lowSpeedOn && sel == 2'b01) begin
          sleepTgt = MODE_HIGH; sleepLegal = 1'b1;
        end else if (ctrl.lowSpeedOn && sel == 2'b00) begin
          sleepTgt = MODE_SUBSLP; sleepLegal = 1'b1;
        end
      end
      default: sleepLegal = 1'b0;
    endcase
  end

  // return targets for stopped modes
  always_comb begin
    case (mode)
      MODE_SUBSLP: wakeTgt = MODE_SUB;
      MODE_WATCH:  wakeTgt = ctrl.lowSpeedOn ? MODE_SUB : MODE_HIGH;
      default:     wakeTgt = origMed ? MODE_MED : MODE_HIGH;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.nextMode = mode;
    if (mode == MODE_BAD) begin
      strb.loadMode = 1'b1;
      strb.nextMode = MODE_HIGH;
    end else if (sleepStrobe && cpuRun && sleepLegal) begin
      strb.loadMode = 1'b1;
      strb.nextMode = sleepTgt;
    end else if (wakeStrobe && isStopped) begin
      strb.loadMode = 1'b1;
      strb.nextMode = wakeTgt;
    end else if (cpuRun && mode == MODE_HIGH && ctrl.mediumSel) begin
      strb.loadMode = 1'b1;
      strb.nextMode = MODE_MED;
    end else if (cpuRun && mode == MODE_MED && !ctrl.mediumSel) begin
      strb.loadMode = 1'b1;
      strb.nextMode = MODE_HIGH;
    end
    strb.saveOrigin = strb.loadMode && isFast &&
                      (strb.nextMode == MODE_SLEEP || strb.nextMode == MODE_STBY);
    strb.originMed  = (mode == MODE_MED);
    strb.setWait    = strb.loadMode && mainOff &&
                      (strb.nextMode == MODE_HIGH || strb.nextMode == MODE_MED);
    strb.clrWait    = waitOsc && oscReady;
  end

endmodule

// File: rtl/pdm_datapath.sv
module pdm_datapath
  import pdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  pdmStrobe_t        strb,
  output pdmMode_e          mode,
  output pdmCtrl_t          ctrl,
  output logic              waitOsc,
  output logic              origMed,
  output logic [DATA_W-1:0] ctrlRd,
  output logic              mainClkEn,
  output logic              cpuClkEn
);

  pdmMode_e modeReg;
  pdmCtrl_t ctrlReg;
  logic     waitReg;
  logic     origReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (regWrEn) begin
      ctrlReg <= pdmCtrl_t'(regWrData[CTRL_BITS-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_HIGH;
      origReg <= 1'b0;
      waitReg <= 1'b0;
    end else begin
      if (strb.loadMode) modeReg <= strb.nextMode;
      if (strb.saveOrigin) origReg <= strb.originMed;
      if (strb.setWait) waitReg <= 1'b1;
      else if (strb.clrWait) waitReg <= 1'b0;
    end
  end

  always_comb begin
    ctrlRd = '0;
    ctrlRd[CTRL_BITS-1:0] = ctrlReg;
  end

  assign mode      = modeReg;
  assign ctrl      = ctrlReg;
  assign waitOsc   = waitReg;
  assign origMed   = origReg;
  assign mainClkEn = (modeReg == MODE_HIGH) || (modeReg == MODE_MED) ||
                     (modeReg == MODE_SLEEP);
  assign cpuClkEn  = (((modeReg == MODE_HIGH) || (modeReg == MODE_MED)) && !waitReg) ||
                     (modeReg == MODE_SUB);

endmodule

// File: rtl/pdm_mode_ctrl_top.sv
module pdm_mode_ctrl_top
  import pdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] ctrlRd,
  input  logic              sleepStrobe,
  input  logic              wakeStrobe,
  input  logic              oscReady,
  output logic [2:0]        modeCode,
  output logic              mainClkEn,
  output logic              cpuClkEn
);

  pdmStrobe_t strb;
  pdmMode_e   mode;
  pdmCtrl_t   ctrl;
  logic       waitOsc;
  logic       origMed;

  pdm_ctrl u_ctrl (
    .mode        (mode),
    .ctrl        (ctrl),
    .waitOsc     (waitOsc),
    .origMed     (origMed),
    .sleepStrobe (sleepStrobe),
    .wakeStrobe  (wakeStrobe),
    .oscReady    (oscReady),
    .strb        (strb)
  );

  pdm_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strb      (strb),
    .mode      (mode),
    .ctrl      (ctrl),
    .waitOsc   (waitOsc),
    .origMed   (origMed),
    .ctrlRd    (ctrlRd),
    .mainClkEn (mainClkEn),
    .cpuClkEn  (cpuClkEn)
  );

  assign modeCode = mode;

endmodule

// File: rtl/pdm_mode_chk.sv
module pdm_mode_chk
  import pdm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sleepStrobe,
  input logic              wakeStrobe,
  input logic              oscReady,
  input logic [DATA_W-1:0] ctrlRd,
  input logic [2:0]        modeCode,
  input logic              mainClkEn,
  input logic              cpuClkEn
);

  // R13
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeCode != MODE_BAD);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[DATA_W-1:CTRL_BITS] == '0);

  // R10
  main_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == MODE_SUB || modeCode == MODE_SUBSLP ||
     modeCode == MODE_STBY || modeCode == MODE_WATCH) |-> !mainClkEn);

  // R9
  cpu_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuClkEn && !$past(cpuClkEn) && modeCode == $past(modeCode) &&
     (modeCode == MODE_HIGH || modeCode == MODE_MED)) |-> $past(oscReady));

  // R6
  mode_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode != $past(modeCode)) |->
      ($past(sleepStrobe) || $past(wakeStrobe) ||
       ($past(modeCode) <= MODE_MED && modeCode <= MODE_MED)));

  // R8
  watch_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeCode) == MODE_WATCH && $past(wakeStrobe)) |->
      (modeCode == ($past(ctrlRd[0]) ? MODE_SUB : MODE_HIGH)));

endmodule

bind pdm_mode_ctrl_top pdm_mode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepStrobe (sleepStrobe),
  .wakeStrobe  (wakeStrobe),
  .oscReady    (oscReady),
  .ctrlRd      (ctrlRd),
  .modeCode    (modeCode),
  .mainClkEn   (mainClkEn),
  .cpuClkEn    (cpuClkEn)
);

// File: tb/sim_pdm_mode_ctrl_top.sv
module sim_pdm_mode_ctrl_top;

  localparam int PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic sleepStrobe = 1'b0;
  logic wakeStrobe = 1'b0;
  logic oscReady = 1'b0;
  logic [DW-1:0] ctrlRd;
  logic [2:0] modeCode;
  logic mainClkEn;
  logic cpuClkEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int mMode = 0;
  bit mLs = 0, mSb = 0, mDt = 0, mMed = 0;
  bit mWait = 0, mOrig = 0;

  always #(PERIOD/2) clk = ~clk;

  pdm_mode_ctrl_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .ctrlRd(ctrlRd), .sleepStrobe(sleepStrobe), .wakeStrobe(wakeStrobe),
    .oscReady(oscReady), .modeCode(modeCode), .mainClkEn(mainClkEn),
    .cpuClkEn(cpuClkEn)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(string tag);
    int expMain = (mMode == 0 || mMode == 1 || mMode == 3) ? 1 : 0;
    int expCpu  = (((mMode == 0 || mMode == 1) && !mWait) || mMode == 2) ? 1 : 0;
    int expRd   = {mMed, mDt, mSb, mLs};
    check(tag, "modeCode", int'(modeCode), mMode);
    check(tag, "mainClkEn", int'(mainClkEn), expMain);
    check(tag, "cpuClkEn", int'(cpuClkEn), expCpu);
    check(tag, "ctrlRd", int'(ctrlRd), expRd);
  endtask

  // behavioural model advance for one edge
  task automatic modelEdge();
    int t = -1;
    int nMode = mMode;
    bit nWait = mWait;
    bit nOrig = mOrig;
    bit run = ((mMode == 0 || mMode == 1) && !mWait) || mMode == 2;
    if (!rstN) begin
      mMode = 0; mWait = 0; mOrig = 0; mLs = 0; mSb = 0; mDt = 0; mMed = 0;
      return;
    end
    if (run && sleepStrobe) begin
      if (mMode == 0 && mLs)
        t = (!mSb && !mDt) ? 3 : (mSb && !mDt) ? 5 : (!mSb && mDt) ? 2 : 6;
      else if (mMode <= 1 && !mLs)
        t = (mSb && mDt) ? -1 : mDt ? 6 : mSb ? 5 : 3;
      else if (mMode == 2 && !mLs)
        t = (!mSb && mDt) ? 0 : (mSb && !mDt) ? 6 : -1;
      else if (mMode == 2 && mLs)
        t = (!mSb && !mDt) ? 4 : (mSb && !mDt) ? 6 : -1;
    end
    if (t >= 0) nMode = t;
    else if (wakeStrobe && mMode >= 3)
      nMode = (mMode == 4) ? 2 : (mMode == 6) ? (mLs ? 2 : 0) : (mOrig ? 1 : 0);
    else if (run && mMode == 0 && mMed) nMode = 1;
    else if (run && mMode == 1 && !mMed) nMode = 0;
    if (t == 3 || t == 5) nOrig = (mMode == 1);
    if (nMode != mMode && nMode <= 1 && (mMode == 2 || mMode == 5 || mMode == 6))
      nWait = 1;
    else if (mWait && oscReady)
      nWait = 0;
    if (regWrEn) begin
      mLs = regWrData[0]; mSb = regWrData[1]; mDt = regWrData[2]; mMed = regWrData[3];
    end
    mMode = nMode; mWait = nWait; mOrig = nOrig;
  endtask

  task automatic step(string tag, bit slp, bit wk, bit osc, bit wr, logic [DW-1:0] d);
    sleepStrobe = slp; wakeStrobe = wk; oscReady = osc; regWrEn = wr; regWrData = d;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    sleepStrobe = 0; wakeStrobe = 0; regWrEn = 0;
    compareAll(tag);
  endtask

  task automatic wrCtrl(string tag, logic [DW-1:0] d);
    step(tag, 0, 0, 0, 1, d);
  endtask
  task automatic doSleep(string tag);
    step(tag, 1, 0, 0, 0, '0);
  endtask
  task automatic doWake(string tag);
    step(tag, 0, 1, 0, 0, '0);
  endtask
  task automatic idle(string tag, bit osc);
    step(tag, 0, 0, osc, 0, '0);
  endtask

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); modelEdge();
    end
    @(negedge clk);
    compareAll("R1 reset");
    rstN = 1'b1;
    idle("R1 after release", 0);

    // R2 register and reserved bits
    wrCtrl("R2 reserved", 8'hF0);
    wrCtrl("R2 write", 8'h06);
    wrCtrl("R2 clear", 8'h00);

    // R3 flag clear, high-speed
    doSleep("R3 sleep 00");
    idle("R10 sleep enables", 0);
    doWake("R7 sleep return");
    wrCtrl("R2", 8'h02);
    doSleep("R3 standby 10");
    doWake("R7 standby return R9");
    idle("R9 hold", 0);
    idle("R9 hold", 0);
    idle("R9 ready", 1);
    idle("R9 running", 0);
    wrCtrl("R2", 8'h04);
    doSleep("R3 watch 01");
    doSleep("R12 sleep in watch");
    doWake("R8 watch to high");
    doSleep("R12 sleep while waiting");
    idle("R9 ready", 1);
    wrCtrl("R2", 8'h06);
    doSleep("R6 illegal 11");
    doWake("R12 wake while running");

    // R11 medium speed
    wrCtrl("R11 select medium", 8'h08);
    idle("R11 medium R13", 0);
    doSleep("R3 medium sleep");
    doWake("R7 return medium");
    wrCtrl("R2", 8'h09);
    doSleep("R6 medium with flag");
    wrCtrl("R11 back to high", 8'h01);
    idle("R11 high", 0);

    // R4 flag set, high-speed
    doSleep("R4 sleep 00");
    doWake("R7 sleep return");
    wrCtrl("R2", 8'h03);
    doSleep("R4 standby 10");
    doWake("R7 standby return");
    idle("R9 ready", 1);
    wrCtrl("R2", 8'h05);
    doSleep("R4 subactive 01");
    idle("R10 subactive enables", 0);
    doSleep("R6 subactive 01 flag set");
    wrCtrl("R2", 8'h01);
    doSleep("R5 subsleep 00");
    doWake("R7 subsleep return");
    wrCtrl("R2", 8'h03);
    doSleep("R5 watch 10");
    doWake("R8 watch to subactive");
    wrCtrl("R2", 8'h04);
    doSleep("R5 direct to high");
    doSleep("R12 sleep while waiting");
    idle("R9 hold", 0);
    idle("R9 ready", 1);
    wrCtrl("R2", 8'h07);
    doSleep("R4 watch 11");
    wrCtrl("R2 write in watch", 8'h00);
    doWake("R8 watch to high");
    idle("R9 ready", 1);
    wrCtrl("R2", 8'h05);
    doSleep("R4 subactive");
    wrCtrl("R2", 8'h02);
    doSleep("R5 watch flag clear");
    doWake("R8 watch to high flag clear");
    idle("R9 ready", 1);
    idle("R13 final", 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule